// File: doc/BRIEF.md
# Process-Tagged Address Translation Unit

This unit maps a 32-bit effective address, issued by instruction fetch or by a load/store, onto a physical address. It has two modes. After reset it is in real mode, where the effective address is forwarded unchanged, zero-extended to the physical width.

In virtual mode, the current 8-bit process identifier is joined to the effective page number (bits 31:12 of a 4 KB page). The result is compared against every entry of a small fully associative translation buffer. A matching entry supplies the real page number, and the 12-bit page offset is carried through untouched. If nothing matches, the unit reports a miss. Entries with a stored process identifier of zero are global and match every process.

Each lookup is answered one cycle after the request. Entries are loaded through a direct-indexed write port. Page-table walking, caching and fault vectoring are left to the surrounding logic.

Top module: `addr_xlate_unit`

## Requirements
- R1: In real mode (mode bit 0), a request is answered with `rsp_pa_o` equal to `req_ea_i` zero-extended to PA_W, and with `rsp_hit_o` = 0 and `rsp_miss_o` = 0.
- R2: While `rst_ni` is low and after its release, the unit is in real mode (`vm_o` = 0), `rsp_valid_o` is 0, and all buffer entries are invalid.
- R3: A cycle with `mode_wr_i` = 1 loads `mode_vm_i` into the mode bit at that clock edge: 1 selects virtual mode and 0 selects real mode. A request in the same cycle uses the mode held before the write. Without `mode_wr_i` the mode bit holds.
- R4: In virtual mode an entry matches when three conditions hold: it is valid, its page tag equals `req_ea_i[31:12]`, and its stored identifier equals `pid_i`. On a match, `rsp_pa_o` = {real page number, `req_ea_i[11:0]`} and `rsp_hit_o` = 1.
- R5: An entry whose stored identifier is 0 matches any `pid_i`, provided its valid bit and page tag match.
- R6: In virtual mode, a request that matches no entry gives `rsp_miss_o` = 1, `rsp_hit_o` = 0 and `rsp_pa_o` = 0.
- R7: When several entries match, the entry with the lowest index supplies the real page number.
- R8: `rsp_valid_o` is 1 exactly in the cycle after a cycle with `req_valid_i` = 1. When `rsp_valid_o` is 0, `rsp_pa_o`, `rsp_hit_o` and `rsp_miss_o` are 0. `rsp_hit_o` and `rsp_miss_o` are never both 1.
- R9: A write with `tlb_we_i` = 1 replaces entry `tlb_idx_i` at the clock edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new ones. Writing `tlb_valid_i` = 0 removes the entry from matching.
- R10: The physical width PA_W (default 32, at least 32) sets the real page number width to PA_W-12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_ea_i | input | 32 | Effective address |
| pid_i | input | 8 | Current process identifier |
| mode_wr_i | input | 1 | Mode bit write strobe |
| mode_vm_i | input | 1 | New mode bit value (1 = virtual) |
| tlb_we_i | input | 1 | Buffer entry write strobe |
| tlb_idx_i | input | IDX_W | Entry index to write |
| tlb_valid_i | input | 1 | Valid bit to store |
| tlb_pid_i | input | 8 | Identifier tag to store (0 = global) |
| tlb_epn_i | input | 20 | Effective page tag to store |
| tlb_rpn_i | input | PA_W-12 | Real page number to store |
| vm_o | output | 1 | Current mode bit |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pa_o | output | PA_W | Physical address |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | No entry matched in virtual mode |

## Verification
The assertions run on every cycle. They check the one-cycle request-to-response timing and that the response fields are zero when idle. They also check that hit and miss are exclusive, that a miss gives a zero address, the real-mode pass-through, the offset pass-through on hits, and the mode bit update and hold. Some behaviours depend on buffer contents and can only be shown by the bench scenarios: which entry wins, global-entry matching, a process-identifier mismatch, and the write-then-lookup ordering. The bench compares these against its own model of the buffer, using both directed cases and seeded random traffic over a small page space.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int EA_W  = 32;
  localparam int PID_W = 8;
  localparam int OFF_W = 12;
  localparam int EPN_W = EA_W - OFF_W;

  typedef logic [PID_W-1:0] pid_t;
  typedef logic [EPN_W-1:0] epn_t;
  typedef logic [EA_W-1:0]  ea_t;

  typedef enum logic {MODE_REAL = 1'b0, MODE_VIRT = 1'b1} xlate_mode_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import addr_xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RPN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                widx_i,
  input  logic                            wvalid_i,
  input  pid_t                            wpid_i,
  input  epn_t                            wepn_i,
  input  logic [RPN_W-1:0]                wrpn_i,
  input  pid_t                            lk_pid_i,
  input  epn_t                            lk_epn_i,
  output logic [ENTRIES-1:0]              match_o,
  output logic [ENTRIES-1:0][RPN_W-1:0]   rpn_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_q;
    pid_t             pid_q;
    epn_t             epn_q;
    logic [RPN_W-1:0] rpn_q;
    logic             sel;

    assign sel = we_i && (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        pid_q <= '0;
        epn_q <= '0;
        rpn_q <= '0;
      end else if (sel) begin
        vld_q <= wvalid_i;
        pid_q <= wpid_i;
        epn_q <= wepn_i;
        rpn_q <= wrpn_i;
      end
    end

    // stored pid 0 = global page
    assign match_o[g] = vld_q && (epn_q == lk_epn_i) &&
                        ((pid_q == '0) || (pid_q == lk_pid_i));
    assign rpn_o[g]   = rpn_q;
  end
endmodule

// File: rtl/tlb_prio_mux.sv
module tlb_prio_mux #(
  parameter int ENTRIES = 8,
  parameter int RPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            match_i,
  input  logic [ENTRIES-1:0][RPN_W-1:0] rpn_i,
  output logic                          hit_o,
  output logic [RPN_W-1:0]              rpn_o
);
  // scan downward so the lowest index is assigned last and wins
  always_comb begin
    rpn_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) rpn_o = rpn_i[i];
    end
  end

  assign hit_o = |match_i;
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import addr_xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 32,
  localparam int RPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      req_ea_i,
  input  logic [7:0]       pid_i,
  input  logic             mode_wr_i,
  input  logic             mode_vm_i,
  input  logic             tlb_we_i,
  input  logic [IDX_W-1:0] tlb_idx_i,
  input  logic             tlb_valid_i,
  input  logic [7:0]       tlb_pid_i,
  input  logic [19:0]      tlb_epn_i,
  input  logic [RPN_W-1:0] tlb_rpn_i,
  output logic             vm_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o
);
  xlate_mode_e                  mode_q;
  logic [ENTRIES-1:0]           match;
  logic [ENTRIES-1:0][RPN_W-1:0] rpn_all;
  logic                         tlb_hit;
  logic [RPN_W-1:0]             sel_rpn;
  logic [PA_W-1:0]              pa_d;
  logic                         hit_d, miss_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_REAL;
    else if (mode_wr_i) mode_q <= xlate_mode_e'(mode_vm_i);
  end
  assign vm_o = (mode_q == MODE_VIRT);

  tlb_entry_array #(
    .ENTRIES (ENTRIES),
    .RPN_W   (RPN_W),
    .IDX_W   (IDX_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tlb_we_i),
    .widx_i   (tlb_idx_i),
    .wvalid_i (tlb_valid_i),
    .wpid_i   (tlb_pid_i),
    .wepn_i   (tlb_epn_i),
    .wrpn_i   (tlb_rpn_i),
    .lk_pid_i (pid_i),
    .lk_epn_i (req_ea_i[EA_W-1:OFF_W]),
    .match_o  (match),
    .rpn_o    (rpn_all)
  );

  tlb_prio_mux #(
    .ENTRIES (ENTRIES),
    .RPN_W   (RPN_W)
  ) u_prio (
    .match_i (match),
    .rpn_i   (rpn_all),
    .hit_o   (tlb_hit),
    .rpn_o   (sel_rpn)
  );

  always_comb begin
    if (mode_q == MODE_REAL) begin
      pa_d   = PA_W'(req_ea_i);
      hit_d  = 1'b0;
      miss_d = 1'b0;
    end else if (tlb_hit) begin
      pa_d   = {sel_rpn, req_ea_i[OFF_W-1:0]};
      hit_d  = 1'b1;
      miss_d = 1'b0;
    end else begin
      pa_d   = '0;
      hit_d  = 1'b0;
      miss_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_pa_o    <= req_valid_i ? pa_d : '0;
      rsp_hit_o   <= req_valid_i && hit_d;
      rsp_miss_o  <= req_valid_i && miss_d;
    end
  end
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [31:0]     req_ea_i,
  input logic            mode_wr_i,
  input logic            mode_vm_i,
  input logic            vm_o,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic            rsp_hit_o,
  input logic            rsp_miss_o
);
  p_reset_real_r2: assert property (@(posedge clk_i)
    !rst_ni |-> (!vm_o && !rsp_valid_o));

  p_mode_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (vm_o == $past(mode_vm_i)));

  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_i |=> $stable(vm_o));

  p_real_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !vm_o) |=>
      (rsp_pa_o == PA_W'($past(req_ea_i)) && !rsp_hit_o && !rsp_miss_o));

  p_virt_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && vm_o) |=> (rsp_hit_o != rsp_miss_o));

  p_offset_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && vm_o) |=>
      (rsp_miss_o || rsp_pa_o[11:0] == $past(req_ea_i[11:0])));

  p_miss_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_pa_o == '0 && !rsp_hit_o));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_pa_o == '0 && !rsp_hit_o && !rsp_miss_o));
endmodule

bind addr_xlate_unit addr_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ea_i    (req_ea_i),
  .mode_wr_i   (mode_wr_i),
  .mode_vm_i   (mode_vm_i),
  .vm_o        (vm_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_pa_o    (rsp_pa_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_miss_o  (rsp_miss_o)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  localparam int N = 8;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0;
  logic [31:0] req_ea_i = '0;
  logic [7:0]  pid_i = '0;
  logic        mode_wr_i = 0, mode_vm_i = 0;
  logic        tlb_we_i = 0;
  logic [2:0]  tlb_idx_i = '0;
  logic        tlb_valid_i = 0;
  logic [7:0]  tlb_pid_i = '0;
  logic [19:0] tlb_epn_i = '0;
  logic [19:0] tlb_rpn_i = '0;
  logic        vm_o, rsp_valid_o, rsp_hit_o, rsp_miss_o;
  logic [31:0] rsp_pa_o;

  int errors = 0, checks = 0;
  bit done = 0;

  logic        m_vm;
  logic        m_v   [N];
  logic [7:0]  m_pid [N];
  logic [19:0] m_epn [N];
  logic [19:0] m_rpn [N];

  addr_xlate_unit u_dut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic void model(input logic [31:0] ea, input logic [7:0] pid,
                                output logic [31:0] pa, output logic h, output logic m);
    pa = '0; h = 0; m = 0;
    if (!m_vm) begin
      pa = ea;
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (!h && m_v[i] && m_epn[i] == ea[31:12] && (m_pid[i] == 0 || m_pid[i] == pid)) begin
        h = 1; pa = {m_rpn[i], ea[11:0]};
      end
    end
    m = !h;
  endfunction

  task automatic cyc(input logic req, input logic [31:0] ea, input logic [7:0] pid,
                     input logic mwr, input logic mvm,
                     input logic we, input int idx, input logic wv, input logic [7:0] wp,
                     input logic [19:0] wepn, input logic [19:0] wrpn, input string tag);
    logic [31:0] epa; logic eh, em;
    req_valid_i = req; req_ea_i = ea; pid_i = pid;
    mode_wr_i = mwr; mode_vm_i = mvm;
    tlb_we_i = we; tlb_idx_i = 3'(idx); tlb_valid_i = wv; tlb_pid_i = wp;
    tlb_epn_i = wepn; tlb_rpn_i = wrpn;
    model(ea, pid, epa, eh, em);
    if (!req) begin epa = '0; eh = 0; em = 0; end
    if (mwr) m_vm = mvm;
    if (we) begin m_v[idx] = wv; m_pid[idx] = wp; m_epn[idx] = wepn; m_rpn[idx] = wrpn; end
    @(posedge clk_i);
    @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== req || rsp_pa_o !== epa || rsp_hit_o !== eh || rsp_miss_o !== em) begin
      errors++;
      $display("FAIL %s: v=%b pa=%h hit=%b miss=%b expected v=%b pa=%h hit=%b miss=%b",
               tag, rsp_valid_o, rsp_pa_o, rsp_hit_o, rsp_miss_o, req, epa, eh, em);
    end
  endtask

  task automatic look(input logic [31:0] ea, input logic [7:0] pid, input string tag);
    cyc(1, ea, pid, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int idx, input logic v, input logic [7:0] p,
                    input logic [19:0] e, input logic [19:0] r);
    cyc(0, 0, 0, 0, 0, 1, idx, v, p, e, r, "R9 write idle");
  endtask

  initial begin
    process::self().srandom(32'd1234);
    m_vm = 0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_pid[i] = 0; m_epn[i] = 0; m_rpn[i] = 0; end
    repeat (3) @(negedge clk_i);
    checks++;
    if (vm_o !== 0 || rsp_valid_o !== 0) begin
      errors++;
      $display("FAIL R2 reset: vm=%b v=%b expected vm=0 v=0", vm_o, rsp_valid_o);
    end
    rst_ni = 1;
    @(negedge clk_i);

    // R1 real mode pass-through, idle response
    look(32'hDEAD_BEEF, 8'h05, "R1 real passthrough");
    look(32'h0000_0000, 8'h00, "R1 real zero");
    cyc(0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle response");
    checks++;
    if (vm_o !== 0) begin errors++; $display("FAIL R2 mode after reset: vm=%b expected 0", vm_o); end

    // R3 request in same cycle as mode write uses old mode
    cyc(1, 32'hCAFE_0123, 8'h01, 1, 1, 0, 0, 0, 0, 0, 0, "R3 old mode on write");
    checks++;
    if (vm_o !== 1) begin errors++; $display("FAIL R3 mode set: vm=%b expected 1", vm_o); end
    look(32'hCAFE_0123, 8'h01, "R6 miss empty buffer");

    // R9 write + lookup same cycle sees old, next cycle sees new
    cyc(1, 32'h0001_2ABC, 8'h07, 0, 0, 1, 3, 1, 8'h07, 20'h00012, 20'hABCDE, "R9 same-cycle old");
    look(32'h0001_2ABC, 8'h07, "R4 hit after write");
    look(32'h0001_2ABC, 8'h08, "R4 pid mismatch miss");
    // R5 global entry
    wr(6, 1, 8'h00, 20'h00040, 20'h55555);
    look(32'h0004_0FFF, 8'h99, "R5 global any pid");
    // R7 lowest index wins
    wr(5, 1, 8'h07, 20'h00077, 20'h22222);
    wr(2, 1, 8'h00, 20'h00077, 20'h11111);
    look(32'h0007_7001, 8'h07, "R7 lowest index");
    // R9 invalidate
    wr(2, 0, 8'h00, 20'h00077, 20'h11111);
    look(32'h0007_7001, 8'h07, "R9 invalidate falls to next");
    // R3 back to real mode
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 clear mode");
    look(32'h0007_7001, 8'h07, "R1 real after clear");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R3 set mode");

    // random traffic over small page/pid space (R4 R5 R6 R7 R8 R9 R10)
    for (int k = 0; k < 400; k++) begin
      automatic logic        rq  = 1'($urandom_range(0, 3) != 0);
      automatic logic [31:0] ea  = {18'($urandom_range(0, 3)), 2'b00, 12'($urandom)};
      automatic logic [7:0]  p   = 8'($urandom_range(0, 3));
      automatic logic        we  = 1'($urandom_range(0, 2) == 0);
      automatic logic        mw  = 1'($urandom_range(0, 30) == 0);
      automatic logic [19:0] e   = {$urandom_range(0, 3), 2'b00};
      cyc(rq, ea, p, mw, 1'($urandom_range(0, 4) != 0), we, $urandom_range(0, N - 1),
          1'($urandom_range(0, 5) != 0), 8'($urandom_range(0, 3)), e, 20'($urandom),
          "R4 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule